// File: doc/BRIEF.md
# Error and Interrupt Status/Clear Unit

This unit holds the error and completion status of an external bus interface controller. Three error conditions are turned into sticky status bits: a write stalled because the write FIFO is full, a read held back because writes are still queued, and a wait timeout. Each FIFO-stall error is gated by its own enable bit. The timeout is raised when the not-ready line holds one transaction for longer than a programmable number of cycles. Two DMA completion strobes, one for the read channel and one for the write channel, set their own raw status bits.

Software reaches the unit through a small register bus. The raw status, the mask enables and the masked status are readable. A write-one-to-clear register removes error and DMA status. Clearing any error bit also drops the error interrupt enable, so software must re-arm it deliberately. Writes are applied one cycle after they are accepted. As a result, a read placed directly after a clear still returns the previous contents.

Top module: `err_irq_unit`

## Requirements
- R1: After reset, every register reads as zero. At the clear register (address 5), bits 31..3 always read as zero, including the write-only DMA clear strobes at bits 3 (read channel) and 4 (write channel).
- R2: At address 5, bit 0 is timeout, bit 1 is read-stall and bit 2 is write-full. Each is sticky status. Writing 1 to one of these bits clears that bit only. Writing 0 has no effect.
- R3: A clear write with any of bits 2..0 set also clears the error interrupt enable, which is bit 0 of the mask register (address 3).
- R4: Writing 1 to bit 3 of address 5 clears the read DMA raw bit, which is bit 1 at address 2, and its masked bit at address 4. Bit 4 does the same for the write DMA bit, which is bit 2 at those addresses. Neither touches error status or the mask register.
- R5: The write-full error bit sets only when control bit 0 (address 0) is 1 while the write-stall input is high.
- R6: The read-stall error bit sets only when control bit 1 (address 0) is 1 while the read-stall input is high.
- R7: With maximum wait M ≠ 0 (address 1), the timeout bit sets once not-ready has been high for M+1 consecutive cycles of one transaction. It does not set after M cycles. It is raised once per transaction, and a transaction start restarts the count.
- R8: A maximum wait of 0 disables the timeout.
- R9: The aggregate error flag (bit 0 at address 2) is the OR of the three error bits. Masked status at address 4 is the raw status ANDed with the mask. The irq output is the OR of the masked bits, one cycle later.
- R10: A read issued in the cycle after a write returns the value from before that write. The next read returns the updated value.
- R11: When a set event and a clear write reach the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address of the previous cycle |
| wr_stall_full | input | 1 | Write stalled on full write FIFO |
| rd_stall_pend | input | 1 | Read held by queued writes |
| xfer_start | input | 1 | Start of a bus transaction |
| not_ready | input | 1 | Target not ready, wait state |
| dma_rd_done | input | 1 | Read DMA completion strobe |
| dma_wr_done | input | 1 | Write DMA completion strobe |
| irq | output | 1 | Interrupt request |

## Verification
All eight patterns of the three error clear bits are applied to a fully set status word. This separates per-bit clearing from whole-word clearing, and a clear that drops the interrupt enable from one that leaves it alone. A grid of maximum-wait values against stall lengths shows where the M versus M+1 boundary lies and shows that zero disables the timeout. DMA clears are applied while errors are pending, which shows whether they leak into error status or the mask. A read placed right after a clear, and a stall event placed in the same cycle as a clear, pin down the write latency and the set-over-clear priority.

// File: rtl/err_irq_pkg.sv
`timescale 1ns/1ps
package err_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_MAXW  = 3'd1,
    SEL_RAW   = 3'd2,
    SEL_MASK  = 3'd3,
    SEL_MSTAT = 3'd4,
    SEL_CLR   = 3'd5
  } reg_sel_e;

  // clear register bit positions
  localparam int CB_TOUT  = 0;
  localparam int CB_RSTL  = 1;
  localparam int CB_WFULL = 2;
  localparam int CB_DRD   = 3;
  localparam int CB_DWR   = 4;
  localparam int CLR_W    = 5;
  localparam int ERR_N    = 3;

  // raw / mask / masked status bit positions
  localparam int ST_ERR = 0;
  localparam int ST_DRD = 1;
  localparam int ST_DWR = 2;
  localparam int ST_W   = 3;
endpackage

// File: rtl/err_wait_timer.sv
`timescale 1ns/1ps
module err_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              not_ready,
  input  logic [WAIT_W-1:0] max_wait,
  output logic              tout_ev
);
  localparam int CNT_W = WAIT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim     = {1'b0, max_wait};
  assign tout_ev = not_ready && !start && (max_wait != '0) && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || start || !not_ready) cnt <= '0;
    else if (cnt <= lim)            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/err_regbus.sv
`timescale 1ns/1ps
module err_regbus
  import err_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [ERR_N-1:0]         err_q,
  input  logic [ST_W-1:0]          raw,
  input  logic [ST_W-1:0]          mask_q,
  input  logic [ST_W-1:0]          mstat,
  output logic                     st_we,
  output logic [ADDR_W-1:0]        st_sel,
  output logic [WAIT_W-1:0]        st_data,
  output logic [1:0]               ctrl_q,
  output logic [WAIT_W-1:0]        maxw_q,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:WAIT_W];

  // write staging: accepted writes land one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      st_we   <= 1'b0;
      st_sel  <= '0;
      st_data <= '0;
    end else begin
      st_we   <= we;
      st_sel  <= addr;
      st_data <= wdata[WAIT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      maxw_q <= '0;
    end else if (st_we) begin
      if (st_sel == SEL_CTRL) ctrl_q <= st_data[1:0];
      if (st_sel == SEL_MAXW) maxw_q <= st_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      SEL_CTRL:  rd_mux[1:0]        = ctrl_q;
      SEL_MAXW:  rd_mux[WAIT_W-1:0] = maxw_q;
      SEL_RAW:   rd_mux[ST_W-1:0]   = raw;
      SEL_MASK:  rd_mux[ST_W-1:0]   = mask_q;
      SEL_MSTAT: rd_mux[ST_W-1:0]   = mstat;
      SEL_CLR:   rd_mux[ERR_N-1:0]  = err_q;
      default:   rd_mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/err_status_core.sv
`timescale 1ns/1ps
module err_status_core
  import err_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         ctrl_q,
  input  logic               wr_stall_full,
  input  logic               rd_stall_pend,
  input  logic               tout_ev,
  input  logic               dma_rd_done,
  input  logic               dma_wr_done,
  input  logic               st_we,
  input  logic [ADDR_W-1:0]  st_sel,
  input  logic [CLR_W-1:0]   st_data,
  output logic [ERR_N-1:0]   err_q,
  output logic [1:0]         dma_q,
  output logic [ST_W-1:0]    mask_q,
  output logic [ST_W-1:0]    raw,
  output logic [ST_W-1:0]    mstat,
  output logic               irq
);
  logic             clr_hit;
  logic [ERR_N-1:0] err_set;
  logic [ERR_N-1:0] err_clr;
  logic [1:0]       dma_set;
  logic [1:0]       dma_clr;

  assign clr_hit = st_we && (st_sel == SEL_CLR);
  assign err_clr = clr_hit ? st_data[ERR_N-1:0] : '0;
  assign dma_clr = clr_hit ? st_data[CB_DWR:CB_DRD] : '0;

  assign err_set[CB_TOUT]  = tout_ev;
  assign err_set[CB_RSTL]  = ctrl_q[1] && rd_stall_pend;
  assign err_set[CB_WFULL] = ctrl_q[0] && wr_stall_full;
  assign dma_set           = {dma_wr_done, dma_rd_done};

  // sticky bits: set wins over a clear in the same cycle
  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) err_q[i] <= 1'b0;
      else     err_q[i] <= (err_q[i] && !err_clr[i]) || err_set[i];
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_dma
    always_ff @(posedge clk) begin
      if (rst) dma_q[j] <= 1'b0;
      else     dma_q[j] <= (dma_q[j] && !dma_clr[j]) || dma_set[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               mask_q         <= '0;
    else if (st_we && st_sel == SEL_MASK)  mask_q         <= st_data[ST_W-1:0];
    else if (|err_clr)                     mask_q[ST_ERR] <= 1'b0;
  end

  assign raw[ST_ERR] = |err_q;
  assign raw[ST_DRD] = dma_q[0];
  assign raw[ST_DWR] = dma_q[1];
  assign mstat       = raw & mask_q;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |mstat;
  end
endmodule

// File: rtl/err_irq_unit.sv
`timescale 1ns/1ps
module err_irq_unit
  import err_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wr_stall_full,
  input  logic              rd_stall_pend,
  input  logic              xfer_start,
  input  logic              not_ready,
  input  logic              dma_rd_done,
  input  logic              dma_wr_done,
  output logic              irq
);
  logic              st_we;
  logic [ADDR_W-1:0] st_sel;
  logic [WAIT_W-1:0] st_data;
  logic [1:0]        ctrl_q;
  logic [WAIT_W-1:0] maxw_q;
  logic [ERR_N-1:0]  err_q;
  logic [1:0]        dma_q;
  logic [ST_W-1:0]   mask_q;
  logic [ST_W-1:0]   raw;
  logic [ST_W-1:0]   mstat;
  logic              tout_ev;

  err_regbus #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_bus (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .err_q(err_q), .raw(raw), .mask_q(mask_q), .mstat(mstat),
    .st_we(st_we), .st_sel(st_sel), .st_data(st_data),
    .ctrl_q(ctrl_q), .maxw_q(maxw_q), .rdata(bus_rdata)
  );

  err_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst(rst), .start(xfer_start), .not_ready(not_ready),
    .max_wait(maxw_q), .tout_ev(tout_ev)
  );

  err_status_core u_core (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q),
    .wr_stall_full(wr_stall_full), .rd_stall_pend(rd_stall_pend),
    .tout_ev(tout_ev), .dma_rd_done(dma_rd_done), .dma_wr_done(dma_wr_done),
    .st_we(st_we), .st_sel(st_sel), .st_data(st_data[CLR_W-1:0]),
    .err_q(err_q), .dma_q(dma_q), .mask_q(mask_q), .raw(raw),
    .mstat(mstat), .irq(irq)
  );
endmodule

// File: rtl/err_irq_unit_chk.sv
`timescale 1ns/1ps
module err_irq_unit_chk
  import err_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WAIT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wr_stall_full,
  input logic              rd_stall_pend,
  input logic              dma_rd_done,
  input logic              irq,
  input logic              st_we,
  input logic [ADDR_W-1:0] st_sel,
  input logic [WAIT_W-1:0] st_data,
  input logic [1:0]        ctrl_q,
  input logic [WAIT_W-1:0] maxw_q,
  input logic [ERR_N-1:0]  err_q,
  input logic [1:0]        dma_q,
  input logic [ST_W-1:0]   mask_q
);
  a_r1_clr_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == SEL_CLR) |=> (bus_rdata[DATA_W-1:ERR_N] == '0));

  a_r5_wfull_sets: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[0] && wr_stall_full) |=> err_q[CB_WFULL]);

  a_r6_rstall_gated: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[1] && !err_q[CB_RSTL]) |=> !err_q[CB_RSTL]);

  a_r3_enable_dropped: assert property (@(posedge clk) disable iff (rst)
    (st_we && st_sel == SEL_CLR && (st_data[ERR_N-1:0] != '0)) |=> !mask_q[ST_ERR]);

  a_r4_dma_rd_cleared: assert property (@(posedge clk) disable iff (rst)
    (st_we && st_sel == SEL_CLR && st_data[CB_DRD] && !dma_rd_done) |=> !dma_q[0]);

  a_r8_zero_disables: assert property (@(posedge clk) disable iff (rst)
    (maxw_q == '0 && !err_q[CB_TOUT]) |=> !err_q[CB_TOUT]);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1] && rd_stall_pend) |=> err_q[CB_RSTL]);
endmodule

bind err_irq_unit err_irq_unit_chk #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .wr_stall_full(wr_stall_full), .rd_stall_pend(rd_stall_pend),
  .dma_rd_done(dma_rd_done), .irq(irq),
  .st_we(st_we), .st_sel(st_sel), .st_data(st_data),
  .ctrl_q(ctrl_q), .maxw_q(maxw_q), .err_q(err_q), .dma_q(dma_q),
  .mask_q(mask_q)
);

// File: tb/err_irq_unit_test.sv
`timescale 1ns/1ps
module err_irq_unit_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          wr_stall_full = 1'b0, rd_stall_pend = 1'b0;
  logic          xfer_start = 1'b0, not_ready = 1'b0;
  logic          dma_rd_done = 1'b0, dma_wr_done = 1'b0;
  logic          irq;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;
  logic [DW-1:0] v;

  always #2 clk = ~clk;

  err_irq_unit #(.DATA_W(DW), .WAIT_W(8)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_stall_full(wr_stall_full), .rd_stall_pend(rd_stall_pend),
    .xfer_start(xfer_start), .not_ready(not_ready),
    .dma_rd_done(dma_rd_done), .dma_wr_done(dma_wr_done), .irq(irq)
  );

  task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stall(input int n);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0; not_ready = 1'b1;
    repeat (n) @(negedge clk);
    not_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_all();
    wr_stall_full = 1'b1; rd_stall_pend = 1'b1;
    @(negedge clk);
    wr_stall_full = 1'b0; rd_stall_pend = 1'b0;
    wr(3'd1, 1);
    idle(1);
    stall(2);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk(v, 0, $sformatf("R1 reset addr %0d", a));
    end

    // R5 / R6: enables off -> nothing sets
    wr_stall_full = 1'b1; rd_stall_pend = 1'b1;
    idle(2);
    wr_stall_full = 1'b0; rd_stall_pend = 1'b0;
    rd(3'd5, v);
    chk(v, 0, "R5 R6 disabled stall ignored");

    wr(3'd0, 3);
    idle(1);
    // R2 R3 R9: sweep all clear patterns
    for (int c = 0; c < 8; c++) begin
      set_all();
      rd(3'd5, v);
      chk(v, 7, $sformatf("R5 R6 R7 all set c=%0d", c));
      wr(3'd3, 7);
      idle(1);
      wr(3'd5, c);
      idle(2);
      rd(3'd5, v);
      chk(v, 7 & ~c, $sformatf("R2 clear pattern %0d", c));
      rd(3'd3, v);
      chk(v, (c != 0) ? 6 : 7, $sformatf("R3 enable after clear %0d", c));
      rd(3'd2, v);
      chk(v, ((7 & ~c) != 0) ? 1 : 0, $sformatf("R9 aggregate %0d", c));
      chk(irq, (c == 0) ? 1 : 0, $sformatf("R9 irq %0d", c));
      wr(3'd5, 7);
      idle(2);
    end
    wr(3'd5, 32'hFFFF_FFF8);
    idle(2);
    rd(3'd5, v);
    chk(v, 0, "R1 upper write bits read zero");

    // R7 / R8: max wait versus stall length grid
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 7; n++) begin
        wr(3'd1, m);
        idle(1);
        stall(n);
        rd(3'd5, v);
        chk(v, (m != 0 && n > m) ? 1 : 0, $sformatf("R7 R8 m=%0d n=%0d", m, n));
        wr(3'd5, 1);
        idle(2);
      end
    end

    // R7: once per transaction, then restart
    wr(3'd1, 2);
    idle(1);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0; not_ready = 1'b1;
    idle(4);
    wr(3'd5, 1);
    idle(5);
    rd(3'd5, v);
    chk(v, 0, "R7 single flag per transaction");
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    idle(4);
    rd(3'd5, v);
    chk(v, 1, "R7 restart after start");
    not_ready = 1'b0;
    wr(3'd5, 1);
    idle(2);

    // R4: DMA clears leave errors and mask intact
    set_all();
    wr(3'd3, 7);
    dma_rd_done = 1'b1;
    @(negedge clk);
    dma_rd_done = 1'b0;
    dma_wr_done = 1'b1;
    @(negedge clk);
    dma_wr_done = 1'b0;
    idle(1);
    rd(3'd4, v);
    chk(v, 7, "R9 masked all set");
    wr(3'd5, 32'h08);
    idle(2);
    rd(3'd2, v);
    chk(v, 5, "R4 read DMA raw cleared");
    rd(3'd4, v);
    chk(v, 5, "R4 read DMA masked cleared");
    rd(3'd3, v);
    chk(v, 7, "R4 mask untouched");
    rd(3'd5, v);
    chk(v, 7, "R4 errors untouched");
    wr(3'd5, 32'h10);
    idle(2);
    rd(3'd2, v);
    chk(v, 1, "R4 write DMA raw cleared");

    // R10: read right after clear sees old value
    wr(3'd5, 7);
    rd(3'd5, v);
    chk(v, 7, "R10 stale read");
    rd(3'd5, v);
    chk(v, 0, "R10 updated read");
    idle(1);
    chk(irq, 0, "R9 irq low after all clear");

    // R11: set and clear in the same cycle
    set_all();
    bus_addr = 3'd5; bus_wdata = 4; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; wr_stall_full = 1'b1;
    @(negedge clk);
    wr_stall_full = 1'b0;
    idle(1);
    rd(3'd5, v);
    chk(v, 7, "R11 set beats clear");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule